// File: doc/BRIEF.md
# Receive Word Classifier and Frame Filter

This block sits behind the word aligner of a serial link receiver and looks at one 32-bit word per cycle together with a flag that marks ordered sets. Each word is sorted into one of four kinds: an idle fill word, a link-level primitive, a frame delimiter or frame content. Idles are thrown away. Primitives go straight to the link controller. Words between a start delimiter and an end delimiter are collected as one frame.

Every collected frame is held in a bank of a small multi-bank store until its end delimiter arrives. A CRC-32 is recomputed over the frame, and its length is checked. A frame that passes is replayed, without its CRC word, onto one of two output streams. The choice between the streams is made by a routing byte in the first header word. One stream carries application data and the other carries link service commands. Failing frames never reach either stream. Three counters report the number of accepted frames, the number of frames that failed the check, and the number of frames that were abandoned.

Top module: `rx_decision_filter`

## Requirements
- R1: A word with the ordered-set flag set and code byte `rx_word[23:16] == 8'h01` is an idle. It produces no activity on any output and changes no counter.
- R2: A flagged word whose code byte is not 01, 02 or 03 is a primitive. It appears unchanged on `prim_code`, with `prim_valid` high, in the cycle after it is sampled. This happens whether or not a frame is open, and the open frame is not disturbed.
- R3: A flagged word with code 02 opens a frame and one with code 03 closes it. Unflagged words in between, taken only when `rx_valid` is high, are the frame words. The last frame word is the CRC.
- R4: The CRC uses the polynomial 0x04C11DB7 with an initial value of all ones. Bits are taken from bit 31 of each word downward, with no reflection and no final inversion, over all frame words before the CRC word. A frame whose CRC word differs is discarded and `chk_err_cnt` rises by one.
- R5: No word of a frame appears on an output before its closing delimiter has been checked. An accepted frame is delivered as its words minus the CRC, in order, with the first-word flag on the first word and the last-word flag on the last word.
- R6: An accepted frame whose first word has bits [31:24] equal to 8'h22 goes to the `els_*` stream. Every other accepted frame goes to the `app_*` stream.
- R7: A frame with fewer than HDR_WORDS+1 words (7 by default) is discarded and `chk_err_cnt` rises by one.
- R8: An opening delimiter that arrives while a frame is open drops the open frame and raises `abort_cnt` by one. A new frame starts with that delimiter.
- R9: A frame that grows beyond MAX_WORDS words (16 by default) is dropped and `abort_cnt` rises by one. Its remaining words and its closing delimiter are ignored.
- R10: Unflagged words and closing delimiters that arrive while no frame is open are ignored.
- R11: `good_cnt` rises by one for each accepted frame. Accepted frames are delivered in arrival order, and the two streams are never valid in the same cycle.
- R12: When an opening delimiter arrives and every bank still holds a frame waiting for delivery, the new frame is dropped and `abort_cnt` rises by one.
- R13: After reset all counters read zero and all valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Input word present |
| rx_k | input | 1 | Input word is an ordered set |
| rx_word | input | 32 | Received word |
| prim_valid | output | 1 | Primitive forwarded this cycle |
| prim_code | output | 32 | Forwarded primitive word |
| app_valid | output | 1 | Application stream word valid |
| app_first | output | 1 | First word of an application frame |
| app_last | output | 1 | Last word of an application frame |
| app_data | output | 32 | Application stream word |
| els_valid | output | 1 | Link service stream word valid |
| els_first | output | 1 | First word of a link service frame |
| els_last | output | 1 | Last word of a link service frame |
| els_data | output | 32 | Link service stream word |
| good_cnt | output | CNT_W | Accepted frames |
| chk_err_cnt | output | CNT_W | Frames failing CRC or length check |
| abort_cnt | output | CNT_W | Frames abandoned (restart, overflow, no bank) |

## Verification
The filter is exercised with clean frames carrying both routing values. It is also given a frame with one CRC bit flipped, a frame one word short of the minimum, and a frame one word past the buffer depth. Idles, primitives and stray words are sent outside frames, and a primitive is also placed inside a frame. Further patterns are a second opening delimiter inside a frame and three frames sent back to back. Together these separate a wrong routing decision from a lost frame, a wrong CRC from a wrong length check, and an abort from a silent drop. The back-to-back pattern is timed so that the third frame finds both banks occupied, which tells a bank-full drop apart from corrupted delivery.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam logic [7:0]  CODE_IDLE = 8'h01;
    localparam logic [7:0]  CODE_SOF  = 8'h02;
    localparam logic [7:0]  CODE_EOF  = 8'h03;
    localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT  = 32'hFFFF_FFFF;

    typedef enum logic [2:0] {
        WC_NONE, WC_IDLE, WC_PRIM, WC_SOF, WC_EOF, WC_DATA
    } word_class_e;

    typedef enum logic [1:0] {
        RM_IDLE, RM_RECV, RM_DROP
    } rx_mode_e;

    // One word through the CRC register, most significant bit first.
    function automatic logic [31:0] crc_step(input logic [31:0] crc_in,
                                             input logic [31:0] w);
        logic [31:0] c;
        c = crc_in;
        for (int i = 31; i >= 0; i--) begin
            if (c[31] ^ w[i]) c = {c[30:0], 1'b0} ^ CRC_POLY;
            else              c = {c[30:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/rxd_word_class.sv
module rxd_word_class
    import rxd_pkg::*;
(
    input  logic        valid,
    input  logic        is_k,
    input  logic [7:0]  code,
    output word_class_e cls
);
    always_comb begin
        if (!valid)     cls = WC_NONE;
        else if (!is_k) cls = WC_DATA;
        else begin
            case (code)
                CODE_IDLE: cls = WC_IDLE;
                CODE_SOF:  cls = WC_SOF;
                CODE_EOF:  cls = WC_EOF;
                default:   cls = WC_PRIM;
            endcase
        end
    end
endmodule

// File: rtl/rxd_bank_store.sv
module rxd_bank_store #(
    parameter int NBANK = 2,
    parameter int DEPTH = 16,
    parameter int BW    = 1,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [BW-1:0] wbank,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [BW-1:0] rbank,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    logic [31:0] rd_each [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [31:0] row [DEPTH];
        always_ff @(posedge clk) begin
            if (we && wbank == BW'(b)) row[waddr] <= wdata;
        end
        assign rd_each[b] = row[raddr];
    end

    assign rdata = rd_each[rbank];
endmodule

// File: rtl/rx_decision_filter.sv
module rx_decision_filter
    import rxd_pkg::*;
#(
    parameter int          MAX_WORDS = 16,
    parameter int          NBANK     = 2,
    parameter int          HDR_WORDS = 6,
    parameter int          CNT_W     = 16,
    parameter logic [7:0]  ELS_RCTL  = 8'h22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_k,
    input  logic [31:0]      rx_word,
    output logic             prim_valid,
    output logic [31:0]      prim_code,
    output logic             app_valid,
    output logic             app_first,
    output logic             app_last,
    output logic [31:0]      app_data,
    output logic             els_valid,
    output logic             els_first,
    output logic             els_last,
    output logic [31:0]      els_data,
    output logic [CNT_W-1:0] good_cnt,
    output logic [CNT_W-1:0] chk_err_cnt,
    output logic [CNT_W-1:0] abort_cnt
);
    localparam int IDX_W = $clog2(MAX_WORDS + 1);
    localparam int AW    = $clog2(MAX_WORDS);
    localparam int BW    = (NBANK > 1) ? $clog2(NBANK) : 1;

    typedef struct packed {
        rx_mode_e                    mode;
        logic [IDX_W-1:0]            cnt;
        logic [31:0]                 crc;
        logic                        to_els;
        logic [BW-1:0]               wr_bank;
        logic [BW-1:0]               rd_bank;
        logic [IDX_W-1:0]            idx;
        logic [NBANK-1:0]            full;
        logic [NBANK-1:0]            dest;
        logic [NBANK-1:0][IDX_W-1:0] len;
        logic                        prim_valid;
        logic [31:0]                 prim_code;
        logic                        app_valid, app_first, app_last;
        logic [31:0]                 app_data;
        logic                        els_valid, els_first, els_last;
        logic [31:0]                 els_data;
        logic [CNT_W-1:0]            good_cnt, chk_err_cnt, abort_cnt;
    } state_t;

    state_t      st_d, st_q;
    word_class_e cls;
    logic        wr_en;
    logic [31:0] rd_data;
    logic        rd_last;

    function automatic logic [BW-1:0] bank_next(input logic [BW-1:0] b);
        return (b == BW'(NBANK - 1)) ? '0 : b + BW'(1);
    endfunction

    rxd_word_class u_class (
        .valid (rx_valid),
        .is_k  (rx_k),
        .code  (rx_word[23:16]),
        .cls   (cls)
    );

    rxd_bank_store #(.NBANK(NBANK), .DEPTH(MAX_WORDS), .BW(BW), .AW(AW)) u_store (
        .clk   (clk),
        .we    (wr_en),
        .wbank (st_q.wr_bank),
        .waddr (st_q.cnt[AW-1:0]),
        .wdata (rx_word),
        .rbank (st_q.rd_bank),
        .raddr (st_q.idx[AW-1:0]),
        .rdata (rd_data)
    );

    assign rd_last = (st_q.idx == st_q.len[st_q.rd_bank] - IDX_W'(1));

    always_comb begin
        st_d = st_q;
        wr_en = 1'b0;
        st_d.prim_valid = 1'b0;
        st_d.app_valid  = 1'b0;
        st_d.app_first  = 1'b0;
        st_d.app_last   = 1'b0;
        st_d.els_valid  = 1'b0;
        st_d.els_first  = 1'b0;
        st_d.els_last   = 1'b0;

        // Delivery side: drain the oldest full bank one word per cycle.
        if (st_q.full[st_q.rd_bank]) begin
            if (st_q.dest[st_q.rd_bank]) begin
                st_d.els_valid = 1'b1;
                st_d.els_first = (st_q.idx == '0);
                st_d.els_last  = rd_last;
                st_d.els_data  = rd_data;
            end else begin
                st_d.app_valid = 1'b1;
                st_d.app_first = (st_q.idx == '0);
                st_d.app_last  = rd_last;
                st_d.app_data  = rd_data;
            end
            if (rd_last) begin
                st_d.full[st_q.rd_bank] = 1'b0;
                st_d.rd_bank = bank_next(st_q.rd_bank);
                st_d.idx = '0;
            end else begin
                st_d.idx = st_q.idx + IDX_W'(1);
            end
        end

        // Receive side.
        case (cls)
            WC_PRIM: begin
                st_d.prim_valid = 1'b1;
                st_d.prim_code  = rx_word;
            end
            WC_SOF: begin
                if (st_q.mode == RM_RECV || st_q.full[st_q.wr_bank])
                    st_d.abort_cnt = st_q.abort_cnt + CNT_W'(1);
                if (st_q.full[st_q.wr_bank]) begin
                    st_d.mode = RM_DROP;
                end else begin
                    st_d.mode = RM_RECV;
                    st_d.cnt  = '0;
                    st_d.crc  = CRC_INIT;
                end
            end
            WC_DATA: begin
                if (st_q.mode == RM_RECV) begin
                    if (st_q.cnt == IDX_W'(MAX_WORDS)) begin
                        st_d.mode = RM_DROP;
                        st_d.abort_cnt = st_q.abort_cnt + CNT_W'(1);
                    end else begin
                        wr_en = 1'b1;
                        st_d.cnt = st_q.cnt + IDX_W'(1);
                        st_d.crc = crc_step(st_q.crc, rx_word);
                        if (st_q.cnt == '0) st_d.to_els = (rx_word[31:24] == ELS_RCTL);
                    end
                end
            end
            WC_EOF: begin
                if (st_q.mode == RM_RECV) begin
                    if (st_q.cnt < IDX_W'(HDR_WORDS + 1) || st_q.crc != '0) begin
                        st_d.chk_err_cnt = st_q.chk_err_cnt + CNT_W'(1);
                    end else begin
                        st_d.good_cnt = st_q.good_cnt + CNT_W'(1);
                        st_d.full[st_q.wr_bank] = 1'b1;
                        st_d.dest[st_q.wr_bank] = st_q.to_els;
                        st_d.len[st_q.wr_bank]  = st_q.cnt - IDX_W'(1);
                        st_d.wr_bank = bank_next(st_q.wr_bank);
                    end
                end
                st_d.mode = RM_IDLE;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prim_valid  = st_q.prim_valid;
    assign prim_code   = st_q.prim_code;
    assign app_valid   = st_q.app_valid;
    assign app_first   = st_q.app_first;
    assign app_last    = st_q.app_last;
    assign app_data    = st_q.app_data;
    assign els_valid   = st_q.els_valid;
    assign els_first   = st_q.els_first;
    assign els_last    = st_q.els_last;
    assign els_data    = st_q.els_data;
    assign good_cnt    = st_q.good_cnt;
    assign chk_err_cnt = st_q.chk_err_cnt;
    assign abort_cnt   = st_q.abort_cnt;
endmodule

// File: rtl/rxd_checks.sv
module rxd_checks #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             rx_k,
    input logic [7:0]       rx_code,
    input logic             prim_valid,
    input logic [7:0]       prim_cls,
    input logic             app_valid,
    input logic             app_first,
    input logic             app_last,
    input logic             els_valid,
    input logic             els_first,
    input logic             els_last,
    input logic [CNT_W-1:0] good_cnt,
    input logic [CNT_W-1:0] chk_err_cnt,
    input logic [CNT_W-1:0] abort_cnt
);
    assert_idle_not_forwarded_R1: assert property (@(posedge clk) disable iff (!rst_n)
        prim_valid |-> (prim_cls != 8'h01 && prim_cls != 8'h02 && prim_cls != 8'h03));

    assert_prim_follows_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prim_valid |-> $past(rx_valid && rx_k));

    assert_chk_err_on_eof_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_err_cnt != $past(chk_err_cnt)) |->
            ($past(rx_valid && rx_k && rx_code == 8'h03) && chk_err_cnt == $past(chk_err_cnt) + 1'b1));

    assert_app_flags_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (app_first || app_last) |-> app_valid);

    assert_els_flags_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (els_first || els_last) |-> els_valid);

    assert_abort_on_sof_or_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_cnt != $past(abort_cnt)) |->
            ($past(rx_valid) && ($past(!rx_k) || $past(rx_code) == 8'h02) &&
             abort_cnt == $past(abort_cnt) + 1'b1));

    assert_streams_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(app_valid && els_valid));

    assert_good_on_eof_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (good_cnt != $past(good_cnt)) |->
            ($past(rx_valid && rx_k && rx_code == 8'h03) && good_cnt == $past(good_cnt) + 1'b1));
endmodule

bind rx_decision_filter rxd_checks #(.CNT_W(CNT_W)) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_k        (rx_k),
    .rx_code     (rx_word[23:16]),
    .prim_valid  (prim_valid),
    .prim_cls    (prim_code[23:16]),
    .app_valid   (app_valid),
    .app_first   (app_first),
    .app_last    (app_last),
    .els_valid   (els_valid),
    .els_first   (els_first),
    .els_last    (els_last),
    .good_cnt    (good_cnt),
    .chk_err_cnt (chk_err_cnt),
    .abort_cnt   (abort_cnt)
);

// File: tb/rx_decision_filter_tb_top.sv
`timescale 1ns/1ps
module rx_decision_filter_tb_top;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0, rx_k = 1'b0;
    logic [31:0] rx_word = '0;
    logic prim_valid, app_valid, app_first, app_last, els_valid, els_first, els_last;
    logic [31:0] prim_code, app_data, els_data;
    logic [CNT_W-1:0] good_cnt, chk_err_cnt, abort_cnt;

    always #2.5 clk = ~clk;

    rx_decision_filter dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_k(rx_k), .rx_word(rx_word),
        .prim_valid(prim_valid), .prim_code(prim_code),
        .app_valid(app_valid), .app_first(app_first), .app_last(app_last), .app_data(app_data),
        .els_valid(els_valid), .els_first(els_first), .els_last(els_last), .els_data(els_data),
        .good_cnt(good_cnt), .chk_err_cnt(chk_err_cnt), .abort_cnt(abort_cnt)
    );

    int n_checks = 0, n_fail = 0;
    int exp_good = 0, exp_chk = 0, exp_abort = 0;
    bit done = 0;

    // Stream monitors, sampled away from the active edge.
    logic [31:0] app_d [128]; logic app_f [128]; logic app_l [128]; int app_n = 0;
    logic [31:0] els_d [128]; logic els_f [128]; logic els_l [128]; int els_n = 0;
    logic [31:0] prm_d [128]; int prm_n = 0;

    always @(negedge clk) begin
        if (app_valid && app_n < 128) begin
            app_d[app_n] = app_data; app_f[app_n] = app_first; app_l[app_n] = app_last; app_n++;
        end
        if (els_valid && els_n < 128) begin
            els_d[els_n] = els_data; els_f[els_n] = els_first; els_l[els_n] = els_last; els_n++;
        end
        if (prim_valid && prm_n < 128) begin
            prm_d[prm_n] = prim_code; prm_n++;
        end
    end

    logic [31:0] fw [40];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++)
            for (int b = 31; b >= 0; b--)
                c = (c[31] ^ fw[i][b]) ? ((c << 1) ^ 32'h04C1_1DB7) : (c << 1);
        return c;
    endfunction

    // Builds npay payload words then the CRC word at fw[npay].
    task automatic build(input logic [7:0] rctl, input int npay, input logic [15:0] seed);
        fw[0] = {rctl, 8'h5A, seed};
        for (int i = 1; i < npay; i++) fw[i] = {seed, 16'(i * 16'h1357)} ^ 32'(i << 20);
        fw[npay] = ref_crc(npay);
    endtask

    task automatic put(input logic k, input logic [31:0] w);
        @(posedge clk); #1; rx_valid = 1'b1; rx_k = k; rx_word = w;
    endtask

    task automatic rest(input int n);
        @(posedge clk); #1; rx_valid = 1'b0; rx_k = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_mon();
        app_n = 0; els_n = 0; prm_n = 0;
    endtask

    task automatic send_words(input int n);
        for (int i = 0; i < n; i++) put(1'b0, fw[i]);
    endtask

    task automatic check_counters(input string req);
        check({req, " good_cnt"}, 32'(good_cnt), 32'(exp_good));
        check({req, " chk_err_cnt"}, 32'(chk_err_cnt), 32'(exp_chk));
        check({req, " abort_cnt"}, 32'(abort_cnt), 32'(exp_abort));
    endtask

    task automatic check_stream(input string req, input bit els, input int npay);
        int bad = 0;
        int cnt = els ? els_n : app_n;
        check({req, " word count"}, 32'(cnt), 32'(npay));
        for (int i = 0; i < npay && i < cnt; i++) begin
            if ((els ? els_d[i] : app_d[i]) !== fw[i]) bad++;
            if ((els ? els_f[i] : app_f[i]) !== (i == 0)) bad++;
            if ((els ? els_l[i] : app_l[i]) !== (i == npay - 1)) bad++;
        end
        check({req, " data and flags"}, 32'(bad), 32'd0);
    endtask

    task automatic t_reset();
        check("R13 good_cnt", 32'(good_cnt), 0);
        check("R13 chk_err_cnt", 32'(chk_err_cnt), 0);
        check("R13 abort_cnt", 32'(abort_cnt), 0);
        check("R13 valids", {29'd0, prim_valid, app_valid, els_valid}, 0);
    endtask

    task automatic t_idle_prim();
        clear_mon();
        put(1'b1, 32'hBC01_B5B5); put(1'b1, 32'hBC01_B5B5);
        put(1'b1, 32'hBC47_1234);
        put(1'b1, 32'hBC01_B5B5);
        rest(4);
        check("R1 idle not forwarded, one primitive", 32'(prm_n), 1);
        check("R2 primitive code", prm_d[0], 32'hBC47_1234);
        check("R1 no frame output", 32'(app_n + els_n), 0);
        check_counters("R1");
    endtask

    task automatic t_good_app();
        clear_mon();
        build(8'h01, 9, 16'hA001);
        put(1'b1, 32'hBC02_0000);
        send_words(10);
        rest(3);
        check("R5 nothing before EOF", 32'(app_n + els_n), 0);
        put(1'b1, 32'hBC03_0000);
        rest(30);
        exp_good++;
        check_stream("R3 R5 app frame", 1'b0, 9);
        check("R6 nothing on els", 32'(els_n), 0);
        check_counters("R11");
    endtask

    task automatic t_good_els();
        clear_mon();
        build(8'h22, 7, 16'hB002);
        put(1'b1, 32'hBC02_0000); send_words(8); put(1'b1, 32'hBC03_0000);
        rest(30);
        exp_good++;
        check_stream("R6 els frame", 1'b1, 7);
        check("R6 nothing on app", 32'(app_n), 0);
        check_counters("R6");
    endtask

    task automatic t_bad_crc();
        clear_mon();
        build(8'h01, 8, 16'hC003);
        fw[3] = fw[3] ^ 32'h0001_0000;
        put(1'b1, 32'hBC02_0000); send_words(9); put(1'b1, 32'hBC03_0000);
        rest(30);
        exp_chk++;
        check("R4 corrupted frame dropped", 32'(app_n + els_n), 0);
        check_counters("R4");
    endtask

    task automatic t_short();
        clear_mon();
        build(8'h01, 5, 16'hD004);
        put(1'b1, 32'hBC02_0000); send_words(6); put(1'b1, 32'hBC03_0000);
        rest(30);
        exp_chk++;
        check("R7 short frame dropped", 32'(app_n + els_n), 0);
        check_counters("R7");
    endtask

    task automatic t_restart();
        clear_mon();
        build(8'h01, 8, 16'hE005);
        put(1'b1, 32'hBC02_0000); send_words(3);
        put(1'b1, 32'hBC02_0000); send_words(9); put(1'b1, 32'hBC03_0000);
        rest(30);
        exp_abort++; exp_good++;
        check_stream("R8 frame after restart", 1'b0, 8);
        check_counters("R8");
    endtask

    task automatic t_overflow();
        clear_mon();
        build(8'h01, 16, 16'hF006);
        put(1'b1, 32'hBC02_0000); send_words(17); put(1'b1, 32'hBC03_0000);
        rest(30);
        exp_abort++;
        check("R9 oversize frame dropped", 32'(app_n + els_n), 0);
        check_counters("R9");
    endtask

    task automatic t_stray();
        clear_mon();
        put(1'b0, 32'h1111_2222); put(1'b0, 32'h3333_4444);
        put(1'b1, 32'hBC03_0000);
        rest(20);
        check("R10 stray words ignored", 32'(app_n + els_n + prm_n), 0);
        check_counters("R10");
    endtask

    task automatic t_prim_in_frame();
        clear_mon();
        build(8'h22, 8, 16'h1707);
        put(1'b1, 32'hBC02_0000); send_words(4);
        put(1'b1, 32'hBC66_0F0F);
        put(1'b1, 32'hBC01_B5B5);
        for (int i = 4; i < 9; i++) put(1'b0, fw[i]);
        put(1'b1, 32'hBC03_0000);
        rest(30);
        exp_good++;
        check("R2 primitive inside frame", 32'(prm_n), 1);
        check("R2 primitive code inside frame", prm_d[0], 32'hBC66_0F0F);
        check_stream("R2 frame undisturbed", 1'b1, 8);
        check_counters("R2");
    endtask

    task automatic t_no_bank();
        logic [31:0] first_a, first_b;
        clear_mon();
        build(8'h01, 15, 16'h2808); first_a = fw[0];
        put(1'b1, 32'hBC02_0000); send_words(16); put(1'b1, 32'hBC03_0000);
        build(8'h01, 6, 16'h3909); first_b = fw[0];
        put(1'b1, 32'hBC02_0000); send_words(7); put(1'b1, 32'hBC03_0000);
        build(8'h22, 7, 16'h4A0A);
        put(1'b1, 32'hBC02_0000); send_words(8); put(1'b1, 32'hBC03_0000);
        rest(60);
        exp_good += 2; exp_abort++;
        check("R12 words delivered from two frames", 32'(app_n), 21);
        check("R12 third frame dropped", 32'(els_n), 0);
        check("R11 order first frame", app_d[0], first_a);
        check("R11 order second frame", app_d[15], first_b);
        check("R11 frame boundary flags", {30'd0, app_l[14], app_f[15]}, 32'd3);
        check_counters("R12");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1; rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_prim();
        t_good_app();
        t_good_els();
        t_bad_crc();
        t_short();
        t_restart();
        t_overflow();
        t_stray();
        t_prim_in_frame();
        t_no_bank();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule